// File: doc/BRIEF.md
# Ethernet Receive Ring Writer

This block takes incoming Ethernet frames as a byte stream and stores the ones it accepts in a circular packet buffer. The buffer is divided into 256-byte pages. Two page registers bound the ring: a first page and a one-past-last page. A current-page register holds the page where the next frame will start. The reader's boundary page marks how far the host has consumed the ring. When a frame starts, the block first checks that receive is not stopped and that the ring has room for a maximum-size frame. Once the six destination bytes have arrived, it decides whether to keep the frame. That decision depends on three receive-configuration bits and the 6-byte station address.

An accepted frame is written byte by byte, starting four bytes into its first page. Frames shorter than the minimum are padded with zeros. After the payload, the block fills in the 4-byte header: status, next page and stored length. It then moves the current page past the frame and pulses the receive interrupt request. A rejected or dropped frame is consumed from the stream and writes nothing. Memory is driven through a byte-wide write port. The source must respect `in_ready`, which is low while the block copies the held destination bytes, writes padding or writes the header.

Top module: `rx_ring_writer`

## Requirements
- R1: While `rx_stop` is high at the first byte of a frame, the frame is consumed without any memory write, and the current page and interrupt are left unchanged.
- R2: With `rx_cfg` bit 4 set, every frame of six or more bytes is accepted, whatever its destination.
- R3: A destination of six 0xFF bytes is accepted only when `rx_cfg` bit 2 is set (bit 4 clear).
- R4: A destination whose first byte has bit 0 set, and which is not broadcast, is accepted only when `rx_cfg` bit 3 is set (bit 4 clear).
- R5: Any other destination is accepted only when all six bytes equal `station_addr`. Byte 0 of the frame is compared with `station_addr[7:0]`.
- R6: Free bytes are counted at the first byte. If current page < boundary page, free = (boundary − current)·256. Otherwise free = (stop − start)·256 − (current − boundary)·256. The frame is dropped without writes if free < MAX_FRAME + 4.
- R7: A frame shorter than 60 bytes is stored padded with zero bytes up to 60 bytes. The stored length then counts 60.
- R8: Frame byte k is written at current·256 + 4 + k. An address that reaches stop·256 continues at start·256.
- R9: Four header bytes follow the data, at current·256 + 0..3. They hold: status (bit 0 set, bit 5 set when frame byte 0 has bit 0 set); the next page; stored length L+4 low byte; and its high byte. The next page is current + ceil((L+8)/256), minus (stop − start) if the result is ≥ stop.
- R10: Reset leaves `cur_page` at 0 and `rx_int` low. In the cycle of the last header write, `rx_int` pulses high for one cycle and `cur_page` takes the next page.
- R11: A frame that ends before its sixth byte, or that fails address filtering, is drained with no memory write. The following frame is handled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_sof | input | 1 | First byte of a frame |
| in_last | input | 1 | Last byte of a frame |
| in_data | input | 8 | Frame byte |
| in_ready | output | 1 | Block takes the byte this cycle |
| rx_stop | input | 1 | Receive stopped |
| rx_cfg | input | 8 | Receive configuration (bit 2 broadcast, bit 3 multicast, bit 4 all) |
| station_addr | input | 48 | Station address, byte 0 in bits 7:0 |
| ring_start | input | PAGE_W | First page of the ring |
| ring_stop | input | PAGE_W | One past the last page of the ring |
| ring_bound | input | PAGE_W | Reader boundary page |
| cur_wr | input | 1 | Load `cur_wdata` into the current page |
| cur_wdata | input | PAGE_W | Value for the current page |
| cur_page | output | PAGE_W | Current write page |
| mem_we | output | 1 | Buffer write strobe |
| mem_addr | output | PAGE_W+8 | Buffer byte address |
| mem_wdata | output | 8 | Buffer write data |
| rx_int | output | 1 | One-cycle receive interrupt request |

## Verification
The filter is tried with destinations of four kinds: the station address, a different unicast address, broadcast and multicast. Each kind is sent with the configuration bit that enables it and without it. This shows that each bit opens only its own class. Frame lengths of 4, 20, 59, 60, 64 and 600 bytes separate the runt drop, the padding path, the exact-minimum case and long frames. Runs of 600-byte frames force data and next-page wrap at the ring end. Boundary settings of five and six free pages on either side of the current page sit just below and just above the room threshold, in both branches of the free-space formula.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_DEST,
    S_FLUSH,
    S_DATA,
    S_PAD,
    S_HDR,
    S_DRAIN
  } rxw_state_e;

  localparam int CFG_BCAST = 2;
  localparam int CFG_MCAST = 3;
  localparam int CFG_ALL   = 4;
  localparam int ST_OK     = 0;
  localparam int ST_GROUP  = 5;
  localparam int DEST_LEN  = 6;
  localparam int HDR_LEN   = 4;
endpackage

// File: rtl/rxw_filter.sv
module rxw_filter
  import rxw_pkg::*;
(
  input  logic [47:0] dest,
  input  logic [47:0] station,
  input  logic [7:0]  cfg,
  output logic        accept
);
  logic is_bcast;
  logic is_group;

  assign is_bcast = &dest;
  assign is_group = dest[0];

  always_comb begin
    if (cfg[CFG_ALL])     accept = 1'b1;
    else if (is_bcast)    accept = cfg[CFG_BCAST];
    else if (is_group)    accept = cfg[CFG_MCAST];
    else                  accept = (dest == station);
  end
endmodule

// File: rtl/rxw_space.sv
module rxw_space #(
  parameter int PAGE_W    = 8,
  parameter int MAX_FRAME = 1514
) (
  input  logic [PAGE_W-1:0] cur,
  input  logic [PAGE_W-1:0] bnd,
  input  logic [PAGE_W-1:0] first,
  input  logic [PAGE_W-1:0] last,
  output logic              room_ok
);
  localparam int SW = PAGE_W + 10;

  logic [SW-1:0] idx, lim, ring, free;

  assign idx  = {2'b00, cur, 8'h00};
  assign lim  = {2'b00, bnd, 8'h00};
  assign ring = {2'b00, last - first, 8'h00};

  always_comb begin
    if (idx < lim) free = lim - idx;
    else           free = ring - (idx - lim);
  end

  assign room_ok = (free >= SW'(MAX_FRAME + 4));
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxw_pkg::*;
#(
  parameter int PAGE_W    = 8,
  parameter int MAX_FRAME = 1514,
  parameter int MIN_FRAME = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_last,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  input  logic              rx_stop,
  input  logic [7:0]        rx_cfg,
  input  logic [47:0]       station_addr,
  input  logic [PAGE_W-1:0] ring_start,
  input  logic [PAGE_W-1:0] ring_stop,
  input  logic [PAGE_W-1:0] ring_bound,
  input  logic              cur_wr,
  input  logic [PAGE_W-1:0] cur_wdata,
  output logic [PAGE_W-1:0] cur_page,
  output logic              mem_we,
  output logic [PAGE_W+7:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              rx_int
);
  localparam int ADDR_W = PAGE_W + 8;
  localparam int CNT_W  = $clog2(MAX_FRAME + 1) + 1;
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_FRAME);
  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_FRAME);

  rxw_state_e        st;
  logic [5:0][7:0]   dest_q, dest_cand;
  logic [CNT_W-1:0]  bcnt, bcnt_inc;
  logic [ADDR_W-1:0] wptr, base;
  logic [2:0]        fl_i;
  logic [1:0]        hd_i;
  logic              last_seen, group_q;
  logic [PAGE_W-1:0] cur_q;
  logic [ADDR_W-1:0] start_a, stop_a;
  logic [15:0]       st_len;
  logic [PAGE_W-1:0] next_pg;
  logic [7:0]        hdr_byte;
  logic              room_ok, addr_ok;

  // named events for the assertions
  logic sof_evt, stop_drop, space_drop, take_evt;
  logic dest_done, reject_evt;
  logic wr_flush, wr_data, wr_pad, wr_hdr;

  function automatic logic [ADDR_W-1:0] step_ptr(
    input logic [ADDR_W-1:0] p,
    input logic [ADDR_W-1:0] lo,
    input logic [ADDR_W-1:0] hi
  );
    logic [ADDR_W-1:0] n;
    n = p + ADDR_W'(1);
    if (n == hi) n = lo;
    return n;
  endfunction

  function automatic logic [PAGE_W-1:0] calc_next(
    input logic [ADDR_W-1:0] b,
    input logic [15:0]       slen,
    input logic [PAGE_W-1:0] ps,
    input logic [PAGE_W-1:0] pe
  );
    logic [ADDR_W:0] span, nx, lim, ring;
    logic [31:0]     raw;
    raw  = (32'(slen) + 32'd4 + 32'd255) & ~32'd255;
    span = (ADDR_W+1)'(raw);
    nx   = {1'b0, b} + span;
    lim  = {1'b0, pe, 8'h00};
    ring = {1'b0, pe - ps, 8'h00};
    if (nx >= lim) nx = nx - ring;
    return nx[ADDR_W-1:8];
  endfunction

  assign start_a = {ring_start, 8'h00};
  assign stop_a  = {ring_stop, 8'h00};
  assign cur_page = cur_q;

  rxw_space #(.PAGE_W(PAGE_W), .MAX_FRAME(MAX_FRAME)) u_space (
    .cur    (cur_q),
    .bnd    (ring_bound),
    .first  (ring_start),
    .last   (ring_stop),
    .room_ok(room_ok)
  );

  always_comb begin
    dest_cand    = dest_q;
    dest_cand[5] = in_data;
  end

  rxw_filter u_filter (
    .dest   (dest_cand),
    .station(station_addr),
    .cfg    (rx_cfg),
    .accept (addr_ok)
  );

  assign sof_evt    = (st == S_IDLE) && in_valid && in_sof;
  assign stop_drop  = sof_evt && rx_stop;
  assign space_drop = sof_evt && !rx_stop && !room_ok;
  assign take_evt   = sof_evt && !rx_stop && room_ok;
  assign dest_done  = (st == S_DEST) && in_valid && (bcnt == CNT_W'(DEST_LEN - 1));
  assign reject_evt = dest_done && !addr_ok;

  assign wr_flush = (st == S_FLUSH);
  assign wr_data  = (st == S_DATA) && in_valid && (bcnt < MAX_C);
  assign wr_pad   = (st == S_PAD);
  assign wr_hdr   = (st == S_HDR);

  assign in_ready = (st == S_IDLE) || (st == S_DEST) || (st == S_DATA) || (st == S_DRAIN);
  assign bcnt_inc = (bcnt < MAX_C) ? bcnt + CNT_W'(1) : bcnt;
  assign st_len   = 16'(bcnt) + 16'(HDR_LEN);
  assign next_pg  = calc_next(base, st_len, ring_start, ring_stop);

  always_comb begin
    case (hd_i)
      2'd0:    hdr_byte = 8'((1 << ST_OK) | (group_q ? (1 << ST_GROUP) : 0));
      2'd1:    hdr_byte = 8'(next_pg);
      2'd2:    hdr_byte = st_len[7:0];
      default: hdr_byte = st_len[15:8];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      dest_q    <= '0;
      bcnt      <= '0;
      wptr      <= '0;
      base      <= '0;
      fl_i      <= '0;
      hd_i      <= '0;
      last_seen <= 1'b0;
      group_q   <= 1'b0;
      cur_q     <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rx_int    <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      rx_int <= 1'b0;
      case (st)
        S_IDLE: begin
          if (sof_evt) begin
            if (!take_evt) begin
              st <= in_last ? S_IDLE : S_DRAIN;
            end else begin
              dest_q[0] <= in_data;
              bcnt      <= CNT_W'(1);
              base      <= {cur_q, 8'h00};
              st        <= in_last ? S_IDLE : S_DEST;
            end
          end
        end
        S_DEST: begin
          if (in_valid) begin
            dest_q[bcnt[2:0]] <= in_data;
            bcnt <= bcnt + CNT_W'(1);
            if (dest_done) begin
              if (addr_ok) begin
                st        <= S_FLUSH;
                fl_i      <= '0;
                wptr      <= step_ptr(step_ptr(step_ptr(step_ptr(base, start_a, stop_a),
                                       start_a, stop_a), start_a, stop_a), start_a, stop_a);
                last_seen <= in_last;
                group_q   <= dest_q[0][0];
              end else begin
                st <= in_last ? S_IDLE : S_DRAIN;
              end
            end else if (in_last) begin
              st <= S_IDLE;
            end
          end
        end
        S_FLUSH: begin
          mem_we    <= 1'b1;
          mem_addr  <= wptr;
          mem_wdata <= dest_q[fl_i];
          wptr      <= step_ptr(wptr, start_a, stop_a);
          fl_i      <= fl_i + 3'd1;
          hd_i      <= '0;
          if (fl_i == 3'(DEST_LEN - 1)) begin
            if (!last_seen)        st <= S_DATA;
            else if (bcnt < MIN_C) st <= S_PAD;
            else                   st <= S_HDR;
          end
        end
        S_DATA: begin
          if (in_valid) begin
            if (wr_data) begin
              mem_we    <= 1'b1;
              mem_addr  <= wptr;
              mem_wdata <= in_data;
              wptr      <= step_ptr(wptr, start_a, stop_a);
              bcnt      <= bcnt_inc;
            end
            if (in_last) begin
              hd_i <= '0;
              st   <= (bcnt_inc < MIN_C) ? S_PAD : S_HDR;
            end
          end
        end
        S_PAD: begin
          mem_we    <= 1'b1;
          mem_addr  <= wptr;
          mem_wdata <= 8'h00;
          wptr      <= step_ptr(wptr, start_a, stop_a);
          bcnt      <= bcnt + CNT_W'(1);
          if (bcnt == MIN_C - CNT_W'(1)) st <= S_HDR;
        end
        S_HDR: begin
          mem_we    <= 1'b1;
          mem_addr  <= base + ADDR_W'(hd_i);
          mem_wdata <= hdr_byte;
          hd_i      <= hd_i + 2'd1;
          if (hd_i == 2'd3) begin
            cur_q  <= next_pg;
            rx_int <= 1'b1;
            st     <= S_IDLE;
          end
        end
        S_DRAIN: begin
          if (in_valid && in_last) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
      if (cur_wr) cur_q <= cur_wdata;
    end
  end

  // R1: a stopped receiver writes nothing for the refused frame
  a_r1_stop_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    stop_drop |=> !mem_we);

  // R6: a frame refused for lack of room writes nothing
  a_r6_space_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    space_drop |=> !mem_we);

  // R11: a frame failing the filter writes nothing
  a_r11_reject_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt |=> !mem_we);

  // R11: one write source at a time
  a_r11_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_flush, wr_data, wr_pad, wr_hdr}));

  // R7: padding bytes are zero
  a_r7_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pad |=> (mem_we && mem_wdata == 8'h00));

  // R8: every write lands inside the ring
  a_r8_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr >= start_a && mem_addr < stop_a));

  // R10: interrupt is a single-cycle pulse together with the last header write
  a_r10_int_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_int |=> !rx_int);

  a_r10_int_with_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    rx_int |-> (mem_we && mem_addr[1:0] == 2'd3));
endmodule

// File: tb/tb_rx_ring_writer.sv
module tb_rx_ring_writer;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready;
  logic rx_stop = 1'b0;
  logic [7:0] rx_cfg = 8'h00;
  logic [47:0] station_addr = 48'h554433221102;
  logic [PW-1:0] ring_start = 8'd1, ring_stop = 8'd13, ring_bound = 8'd1;
  logic cur_wr = 1'b0;
  logic [PW-1:0] cur_wdata = '0;
  logic [PW-1:0] cur_page;
  logic mem_we;
  logic [PW+7:0] mem_addr;
  logic [7:0] mem_wdata;
  logic rx_int;

  always #4 clk = ~clk;

  rx_ring_writer dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_last(in_last),
    .in_data(in_data), .in_ready(in_ready), .rx_stop(rx_stop), .rx_cfg(rx_cfg),
    .station_addr(station_addr), .ring_start(ring_start), .ring_stop(ring_stop),
    .ring_bound(ring_bound), .cur_wr(cur_wr), .cur_wdata(cur_wdata), .cur_page(cur_page),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rx_int(rx_int)
  );

  int checks = 0, fails = 0, int_cnt = 0, exp_int = 0;
  int m_cur = 1;
  bit done = 1'b0;
  string req = "R0";
  logic [23:0] exp_q[$];
  logic [7:0] fr[$];

  task automatic chk(input bit ok, input string r, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", r, act, expv);
    end
  endtask

  // monitor: compares every buffer write against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, {req, " unexpected write"}, {mem_addr, mem_wdata}, 0);
        end else begin
          logic [23:0] e;
          e = exp_q.pop_front();
          chk({mem_addr, mem_wdata} == e, {req, " write"}, {mem_addr, mem_wdata}, e);
        end
      end
      if (rx_int) int_cnt++;
    end
  end

  task automatic make(input logic [47:0] dst, input int len, input int seed);
    fr.delete();
    for (int i = 0; i < len; i++) begin
      if (i < 6) fr.push_back(dst[8*i +: 8]);
      else       fr.push_back(8'((i * 7 + seed) & 8'hff));
    end
  endtask

  task automatic send(input bit acc, input string r);
    req = r;
    if (acc) begin
      int l, sl, base, p, tot, np;
      l = fr.size();
      sl = (l < 60) ? 60 : l;
      base = m_cur * 256;
      p = base + 4;
      for (int i = 0; i < sl; i++) begin
        exp_q.push_back({16'(p), (i < l) ? fr[i] : 8'h00});
        p++;
        if (p == int'(ring_stop) * 256) p = int'(ring_start) * 256;
      end
      tot = sl + 4;
      np = m_cur + (tot + 4 + 255) / 256;
      if (np >= int'(ring_stop)) np -= int'(ring_stop) - int'(ring_start);
      exp_q.push_back({16'(base),     fr[0][0] ? 8'h21 : 8'h01});
      exp_q.push_back({16'(base + 1), 8'(np)});
      exp_q.push_back({16'(base + 2), 8'(tot & 255)});
      exp_q.push_back({16'(base + 3), 8'(tot >> 8)});
      m_cur = np;
      exp_int++;
    end
    for (int i = 0; i < fr.size(); i++) begin
      do begin
        @(negedge clk);
        in_valid = 1'b0;
      end while (!in_ready);
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_last  = (i == fr.size() - 1);
      in_data  = fr[i];
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_last = 1'b0;
    repeat (90) @(negedge clk);
    chk(exp_q.size() == 0, {r, " missing writes"}, exp_q.size(), 0);
    exp_q.delete();
    chk(int'(cur_page) == m_cur, {r, " cur_page"}, cur_page, m_cur);
    chk(int_cnt == exp_int, {r, " interrupt count"}, int_cnt, exp_int);
  endtask

  task automatic bound_ahead(input int k);
    ring_bound = 8'(int'(ring_start) + ((m_cur - int'(ring_start) + k) % 12));
  endtask

  localparam logic [47:0] OTHER = 48'h665544332210;
  localparam logic [47:0] BCAST = 48'hffffffffffff;
  localparam logic [47:0] MCAST = 48'h000000005e01;

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(cur_page == 0, "R10 reset cur_page", cur_page, 0);
    chk(rx_int == 0, "R10 reset rx_int", rx_int, 0);
    chk(mem_we == 0, "R10 reset mem_we", mem_we, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1, "R10 ready after reset", in_ready, 1);
    cur_wr = 1'b1; cur_wdata = 8'd1;
    @(negedge clk);
    cur_wr = 1'b0;
    ring_bound = 8'd1;

    // R5: unicast to the station is kept, R8/R9/R10 layout and header
    make(station_addr, 64, 1);  ring_bound = 8'(m_cur); send(1, "R5");
    make(OTHER, 64, 2);         ring_bound = 8'(m_cur); send(0, "R5");
    // R3: broadcast gated by bit 2
    rx_cfg = 8'h00; make(BCAST, 70, 3); send(0, "R3");
    rx_cfg = 8'h04; make(BCAST, 70, 4); ring_bound = 8'(m_cur); send(1, "R3");
    // R4: multicast gated by bit 3, status bit 5
    rx_cfg = 8'h04; make(MCAST, 80, 5); send(0, "R4");
    rx_cfg = 8'h08; make(MCAST, 80, 6); ring_bound = 8'(m_cur); send(1, "R4");
    // R2: accept-all
    rx_cfg = 8'h10; make(OTHER, 66, 7); ring_bound = 8'(m_cur); send(1, "R2");
    rx_cfg = 8'h00;
    // R7: padding, exact minimum
    make(station_addr, 20, 8); ring_bound = 8'(m_cur); send(1, "R7");
    make(station_addr, 59, 9); ring_bound = 8'(m_cur); send(1, "R7");
    make(station_addr, 60, 10); ring_bound = 8'(m_cur); send(1, "R7");
    // R11: runts dropped, next frame still handled
    make(station_addr, 4, 11); send(0, "R11");
    make(station_addr, 64, 12); ring_bound = 8'(m_cur); send(1, "R11");
    // R1: stopped receiver
    rx_stop = 1'b1; make(station_addr, 64, 13); send(0, "R1");
    rx_stop = 1'b0;
    // R6: room threshold in both branches of the formula
    make(station_addr, 100, 14); bound_ahead(5); send(0, "R6");
    make(station_addr, 100, 15); bound_ahead(6); send(1, "R6");
    // R8/R9: long frames force data and next-page wrap
    for (int n = 0; n < 5; n++) begin
      make(station_addr, 600, 20 + n); ring_bound = 8'(m_cur); send(1, "R8");
    end
    make(station_addr, 100, 30); bound_ahead(5); send(0, "R6");
    make(station_addr, 100, 31); bound_ahead(6); send(1, "R9");

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule